// File: doc/BRIEF.md
# Carry-Select Adder with Shared Half-Sum Stage

This block adds two unsigned N-bit operands and a carry input in pure combinational logic, producing an N-bit sum and a carry output. It forms the bitwise XOR and AND of the operands once. Two carry chains then run side by side from that shared stage. One chain assumes an incoming carry of zero and the other assumes one.

The real carry input picks one of the two carry words with a single AND-OR gate per bit. The sum comes from one XOR layer applied after that choice. Because the selection acts on carries and not on finished sums, no second adder and no increment logic is needed. The block is intended as the adder inside a larger multiplier or datapath, where the carry input is known late.

Top module: `csa_logic_opt_adder`

## Requirements
- R1: For every pair of N-bit operands and either carry input, {carry_out, sum} equals opnd_a + opnd_b + carry_in, computed as an unsigned value one bit wider than N.
- R2: With carry_in = 0, the outputs equal the plain sum opnd_a + opnd_b. This path is produced by the chain whose carry into bit 0 is fixed at zero.
- R3: With carry_in = 1, the outputs equal opnd_a + opnd_b + 1. An all-ones operand plus zero plus one gives sum = 0 and carry_out = 1.
- R4: A carry bit from the zero-assumed chain implies the same bit of the one-assumed chain. The selected carry word equals the zero-assumed word when carry_in = 0 and the one-assumed word when carry_in = 1.
- R5: carry_out equals the selected carry out of bit N-1. It is 1 exactly when the full unsigned result needs N+1 bits.
- R6: sum bit 0 equals opnd_a[0] XOR opnd_b[0] XOR carry_in. Each higher sum bit i equals opnd_a[i] XOR opnd_b[i] XOR the selected carry out of bit i-1.
- R7: At bit 0, the zero-assumed carry is a0 AND b0 and the one-assumed carry is a0 OR b0. All eight combinations of a0, b0 and carry_in, with the higher operand bits set to propagate, give the correct carry at carry_out.
- R8: N is a parameter of at least 2. The block gives correct results at N = 8, 16 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | First unsigned operand |
| opnd_b | input | N | Second unsigned operand |
| carry_in | input | 1 | Incoming carry, selects the carry word |
| sum | output | N | Low N bits of the result |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The assertions assume the inputs hold two-state values. They also assume each check is made only after the combinational network has settled on a new input set. The bench meets both conditions: it drives only 0 and 1 values, and it waits a fixed delay after every input change before it looks at the outputs. Stimulus covers the whole input space at 8 bits. At 16 and 32 bits it uses full-length carry chains, alternating bit patterns and pseudo-random operands.

// File: rtl/csa_pkg.sv
// Package: shared constants for the carry-select adder.
// Assumes: nothing; holds compile-time limits only.
package csa_pkg;
    localparam int CSA_MIN_WIDTH = 2;
    localparam int CSA_DEF_WIDTH = 16;
endpackage

// File: rtl/csa_half_sum_gen.sv
// Module: per-bit XOR and AND of the two operands (shared by both carry chains).
// Assumes: operands are unsigned, N >= 2.
module csa_half_sum_gen #(
    parameter int N = csa_pkg::CSA_DEF_WIDTH
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    output logic [N-1:0] hsum,
    output logic [N-1:0] hcarry
);
    // Purpose: one half-adder per bit position.
    always_comb begin
        hsum   = opnd_a ^ opnd_b;
        hcarry = opnd_a & opnd_b;
    end
endmodule

// File: rtl/csa_carry_gen.sv
// Module: ripples a full-carry word for a fixed carry into bit 0.
// Assumes: FIXED_CIN is 0 or 1; bit 0 is reduced for that constant.
module csa_carry_gen #(
    parameter int N         = csa_pkg::CSA_DEF_WIDTH,
    parameter bit FIXED_CIN = 1'b0
) (
    input  logic [N-1:0] hsum,
    input  logic [N-1:0] hcarry,
    output logic [N-1:0] carry_word
);
    generate
        if (FIXED_CIN) begin : g_lsb_one
            // Purpose: bit 0 with an incoming carry of one.
            always_comb carry_word[0] = hsum[0] | hcarry[0];
        end else begin : g_lsb_zero
            // Purpose: bit 0 with an incoming carry of zero.
            always_comb carry_word[0] = hcarry[0];
        end
        for (genvar i = 1; i < N; i++) begin : g_chain
            // Purpose: propagate-or-generate step for bit i.
            always_comb carry_word[i] = (carry_word[i-1] & hsum[i]) | hcarry[i];
        end
    endgenerate
endmodule

// File: rtl/csa_carry_select.sv
// Module: chooses the carry word with one AND-OR per bit.
// Assumes: carry0 implies carry1 bitwise, so OR-ing carry0 is safe.
module csa_carry_select #(
    parameter int N = csa_pkg::CSA_DEF_WIDTH
) (
    input  logic [N-1:0] carry0,
    input  logic [N-1:0] carry1,
    input  logic         carry_in,
    output logic [N-1:0] carry_sel
);
    // Purpose: selection folded into AND-OR using the implication.
    always_comb carry_sel = carry0 | ({N{carry_in}} & carry1);
endmodule

// File: rtl/csa_final_sum.sv
// Module: single XOR layer forming the sum from half-sum and selected carry.
// Assumes: carry_sel[i] is the carry out of bit i.
module csa_final_sum #(
    parameter int N = csa_pkg::CSA_DEF_WIDTH
) (
    input  logic [N-1:0] hsum,
    input  logic [N-1:0] carry_sel,
    input  logic         carry_in,
    output logic [N-1:0] sum,
    output logic         carry_out
);
    // Purpose: shift carries up by one bit and XOR with half-sum.
    always_comb begin
        sum       = hsum ^ {carry_sel[N-2:0], carry_in};
        carry_out = carry_sel[N-1];
    end
endmodule

// File: rtl/csa_logic_opt_adder.sv
// Module: top of the N-bit carry-select adder with shared half-sum stage.
// Assumes: unsigned operands, two-state inputs, N >= 2; purely combinational.
module csa_logic_opt_adder #(
    parameter int N = csa_pkg::CSA_DEF_WIDTH
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    input  logic         carry_in,
    output logic [N-1:0] sum,
    output logic         carry_out
);
    generate
        if (N < csa_pkg::CSA_MIN_WIDTH) begin : g_bad_width
            $error("csa_logic_opt_adder: N must be at least 2 (R8)");
        end
    endgenerate

    logic [N-1:0] hsum, hcarry, carry0, carry1, carry_sel;

    csa_half_sum_gen #(.N(N)) u_hsg (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .hsum(hsum), .hcarry(hcarry));

    csa_carry_gen #(.N(N), .FIXED_CIN(1'b0)) u_cg0 (
        .hsum(hsum), .hcarry(hcarry), .carry_word(carry0));

    csa_carry_gen #(.N(N), .FIXED_CIN(1'b1)) u_cg1 (
        .hsum(hsum), .hcarry(hcarry), .carry_word(carry1));

    csa_carry_select #(.N(N)) u_sel (
        .carry0(carry0), .carry1(carry1), .carry_in(carry_in), .carry_sel(carry_sel));

    csa_final_sum #(.N(N)) u_fsg (
        .hsum(hsum), .carry_sel(carry_sel), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out));

    // Purpose: cross-checks between the separately built carry chains and outputs.
    always_comb begin
        p_chain_order_r4: assert ((carry0 & ~carry1) == '0)
            else $error("R4: zero-assumed carry set where one-assumed carry is clear");
        if (!carry_in) begin
            p_sel_zero_r4: assert (carry_sel == carry0)
                else $error("R4: carry_in=0 did not select zero-assumed word");
        end else begin
            p_sel_one_r4: assert (carry_sel == carry1)
                else $error("R4: carry_in=1 did not select one-assumed word");
        end
        p_lsb_sum_r6: assert (sum[0] == (opnd_a[0] ^ opnd_b[0] ^ carry_in))
            else $error("R6: sum bit 0 wrong");
        p_lsb_carry_r7: assert (carry1[0] == (opnd_a[0] | opnd_b[0]))
            else $error("R7: one-assumed bit 0 carry wrong");
    end
endmodule

// File: tb/csa_logic_opt_adder_tb.sv
module csa_logic_opt_adder_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [15:0] a16, b16, s16; logic c16, co16;
    logic [7:0]  a8,  b8,  s8;  logic c8,  co8;
    logic [31:0] a32, b32, s32; logic c32, co32;

    csa_logic_opt_adder #(.N(16)) dut_i (
        .opnd_a(a16), .opnd_b(b16), .carry_in(c16), .sum(s16), .carry_out(co16));
    csa_logic_opt_adder #(.N(8)) dut8_i (
        .opnd_a(a8), .opnd_b(b8), .carry_in(c8), .sum(s8), .carry_out(co8));
    csa_logic_opt_adder #(.N(32)) dut32_i (
        .opnd_a(a32), .opnd_b(b32), .carry_in(c32), .sum(s32), .carry_out(co32));

    task automatic chk(input string req, input logic [32:0] got, input logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply16(input string req, input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [16:0] e;
        a16 = a; b16 = b; c16 = c;
        #1;
        e = {1'b0, a} + {1'b0, b} + {16'd0, c};
        chk(req, {16'd0, co16, s16}, {16'd0, e});
    endtask

    task automatic apply32(input string req, input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [32:0] e;
        a32 = a; b32 = b; c32 = c;
        #1;
        e = {1'b0, a} + {1'b0, b} + {32'd0, c};
        chk(req, {co32, s32}, e);
    endtask

    // Idle state: all-zero inputs give all-zero outputs (R1).
    task automatic t_idle();
        a8 = '0; b8 = '0; c8 = 0; a16 = '0; b16 = '0; c16 = 0; a32 = '0; b32 = '0; c32 = 0;
        #1;
        chk("R1 idle16", {16'd0, co16, s16}, 33'd0);
        chk("R1 idle8",  {24'd0, co8, s8},   33'd0);
        chk("R1 idle32", {co32, s32},        33'd0);
    endtask

    // Exhaustive 8-bit sweep (R1, R2, R3, R8).
    task automatic t_exhaustive8();
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    a8 = a[7:0]; b8 = b[7:0]; c8 = c[0];
                    #1;
                    chk(c == 0 ? "R2 exh8" : "R3 exh8", {24'd0, co8, s8}, 33'(a + b + c));
                end
            end
        end
    endtask

    // Full-length carry chains and wrap (R3, R5).
    task automatic t_chains();
        apply16("R3 ones16+0+1", 16'hFFFF, 16'h0000, 1'b1);
        apply16("R5 ones16+ones16+1", 16'hFFFF, 16'hFFFF, 1'b1);
        apply16("R5 msb16 overflow", 16'h8000, 16'h8000, 1'b0);
        apply16("R2 ones16+0+0", 16'hFFFF, 16'h0000, 1'b0);
        apply32("R3 ones32+0+1", 32'hFFFF_FFFF, 32'h0, 1'b1);
        apply32("R5 ones32+ones32+0", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        apply32("R5 ones32+1+0", 32'hFFFF_FFFF, 32'h1, 1'b0);
    endtask

    // Alternating patterns (R6).
    task automatic t_alternate();
        for (int c = 0; c < 2; c++) begin
            apply16("R6 alt16 a", 16'hAAAA, 16'h5555, c[0]);
            apply16("R6 alt16 b", 16'hAAAA, 16'hAAAA, c[0]);
            apply32("R6 alt32 a", 32'h5555_5555, 32'hAAAA_AAAA, c[0]);
            apply32("R6 alt32 b", 32'h5555_5555, 32'h5555_5555, c[0]);
        end
    endtask

    // Bit-0 carry forms made visible at carry_out (R7).
    task automatic t_bit0();
        for (int k = 0; k < 8; k++) begin
            apply16("R7 bit0 16", {15'h7FFF, k[0]}, {15'h0000, k[1]}, k[2]);
            apply32("R7 bit0 32", {31'h7FFF_FFFF, k[0]}, {31'h0, k[1]}, k[2]);
        end
    endtask

    // Pseudo-random operands at 16 and 32 bits (R1, R8).
    task automatic t_random();
        for (int i = 0; i < 2000; i++) begin
            apply16("R1 rnd16", 16'($urandom), 16'($urandom), 1'($urandom));
            apply32("R8 rnd32", $urandom, $urandom, 1'($urandom));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_idle();
        t_exhaustive8();
        t_chains();
        t_alternate();
        t_bit0();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule